// File: doc/BRIEF.md
# Two-Channel Programmable Interval Timer

The block holds two down-counters, known as counter 0 and counter 2, behind a small byte-wide register interface. Each counter is loaded with two data-port writes, low byte first, and after the second byte it decrements by one on every `tick_i` pulse. `tick_i` is meant to pulse at 1,193,180 per second. Counter 2 also has a terminal-count flag, which software reads through a status port.

Software reads a running count in one of two ways. It can read the live value one byte at a time, or it can first write a latch command that freezes a snapshot and then read the two bytes of that snapshot. A control word selects the counter and the kind of access. Only the latch command and low-then-high loading are supported. Any other control word raises a sticky error output. A 3-bit mode field is kept for each counter but has no effect on counting.

Top module: `pit_two_chan`

## Requirements
- R1: After reset, both counts are 0, the status port reads 0x00, `err_o` is 0, and the first data read of each counter returns its low byte.
- R2: Addresses: 0 is the counter 0 data port, 1 is the counter 2 data port, 2 is the control port (write), 3 is the status port (read). In a control word, bits [7:6] select the counter (00 is counter 0, 10 is counter 2) and bits [5:4] give the access kind (00 is latch, 11 is low-then-high).
- R3: A count is loaded with two writes to its data port. The first write is held as the low byte. The second write supplies the high byte, loads the assembled value and clears counter 2's status flag. Each counter tracks its own first-byte state, so interleaved loads of the two counters do not interfere.
- R4: Every `tick_i` cycle decrements a loaded counter by one, and it wraps from 0 to the all-ones value. The tick that takes counter 2 from 1 to 0 sets status bit 5 (reads 0x20). The flag stays set until counter 2 is loaded again.
- R5: A counter that has never been loaded since reset does not change on `tick_i`.
- R6: The status port reads only 0x00 or 0x20.
- R7: Data-port reads alternate between the low byte and the high byte of the selected counter. Without a latch they return the live count.
- R8: A latch command captures the selected counter's count. Reads then return the captured value until its high byte has been read, after which reads return the live count again.
- R9: A latch command issued while a captured value is still unread is ignored.
- R10: A low-then-high control word stores bits [3:1] as that counter's mode. The mode does not alter loading or counting.
- R11: A control word that selects 01 or 11 in bits [7:6], or 01 or 10 in bits [5:4], sets `err_o`. `err_o` stays set until reset, and such a word leaves both counters untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable pulse |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; advances the byte pointer of a data port |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| err_o | output | 1 | Sticky unsupported-command flag |

## Verification
The bench builds the block with `BYTE_W = 4`, which makes each counter 8 bits wide. This lets it sweep every nonzero load value of counter 2 all the way to terminal count, and check the status flag one tick before and exactly at expiry. A second sweep runs counter 0 over a spread of load values and tick counts, and checks the live count arithmetically, including wrap-around. Directed sequences cover interleaved loads, latch capture and release, latch commands that must be ignored, mode values that must have no effect, and each kind of unsupported control word.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int BUS_W    = 8;
  localparam int NCH      = 2;
  localparam int STAT_BIT = 5;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;
  localparam logic [1:0] ACC_LATCH = 2'b00;
  localparam logic [1:0] ACC_LOHI  = 2'b11;

  // channel index -> counter select code in the control word
  function automatic logic [1:0] chan_sel(int idx);
    return 2'(idx * 2);
  endfunction
endpackage

// File: rtl/pit_ctrl_dec.sv
module pit_ctrl_dec
  import pit_pkg::*;
(
  input  logic           wr_i,
  input  logic [1:0]     addr_i,
  input  logic [7:1]     ctrl_i,
  output logic [NCH-1:0] latch_o,
  output logic [NCH-1:0] mode_wr_o,
  output logic           err_o
);
  logic       is_ctrl;
  logic [1:0] sel, acc;
  logic       sel_ok, acc_ok;

  assign is_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign sel     = ctrl_i[7:6];
  assign acc     = ctrl_i[5:4];
  assign acc_ok  = (acc == ACC_LATCH) || (acc == ACC_LOHI);

  always_comb begin
    sel_ok = 1'b0;
    for (int i = 0; i < NCH; i++) if (sel == chan_sel(i)) sel_ok = 1'b1;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign latch_o[g]   = is_ctrl && (sel == chan_sel(g)) && (acc == ACC_LATCH);
    assign mode_wr_o[g] = is_ctrl && (sel == chan_sel(g)) && (acc == ACC_LOHI);
  end

  assign err_o = is_ctrl && !(sel_ok && acc_ok);
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              data_wr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              rd_i,
  input  logic              latch_i,
  input  logic              mode_wr_i,
  input  logic [2:0]        mode_i,
  output logic [BYTE_W-1:0] rd_byte_o,
  output logic              load_o,
  output logic              armed_o,
  output logic              tc_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  latch_o,
  output logic              latched_o,
  output logic [2:0]        mode_o
);
  logic [CNT_W-1:0]  count_q, latch_q, src;
  logic [BYTE_W-1:0] lo_q;
  logic              pend_q, armed_q, tc_q, latched_q, rd_hi_q;
  logic [2:0]        mode_q;

  assign load_o = data_wr_i && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      lo_q    <= '0;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
      tc_q    <= 1'b0;
    end else begin
      if (data_wr_i) begin
        pend_q <= !pend_q;
        if (!pend_q) lo_q <= data_i;
      end
      if (load_o) begin
        count_q <= {data_i, lo_q};
        armed_q <= 1'b1;
        tc_q    <= 1'b0;
      end else if (armed_q && tick_i) begin
        count_q <= count_q - 1'b1;
        if (count_q == CNT_W'(1)) tc_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q   <= '0;
      latched_q <= 1'b0;
      rd_hi_q   <= 1'b0;
      mode_q    <= '0;
    end else begin
      if (latch_i && !latched_q) begin
        latch_q   <= count_q;
        latched_q <= 1'b1;
      end else if (rd_i && rd_hi_q) begin
        latched_q <= 1'b0;
      end
      if (rd_i) rd_hi_q <= !rd_hi_q;
      if (mode_wr_i) mode_q <= mode_i;
    end
  end

  assign src       = latched_q ? latch_q : count_q;
  assign rd_byte_o = rd_hi_q ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
  assign armed_o   = armed_q;
  assign tc_o      = tc_q;
  assign count_o   = count_q;
  assign latch_o   = latch_q;
  assign latched_o = latched_q;
  assign mode_o    = mode_q;
endmodule

// File: rtl/pit_two_chan.sv
module pit_two_chan
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [1:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             err_o
);
  logic [NCH-1:0]                latch_cmd, mode_wr, err_set;
  logic [NCH-1:0]                ld_v, armed_v, tc_v, latched_v;
  logic [NCH-1:0][CNT_W-1:0]     cnt_v, latch_v;
  logic [NCH-1:0][2:0]           mode_v;
  logic [NCH-1:0][BYTE_W-1:0]    rd_byte;
  logic                          err_q;

  pit_ctrl_dec u_dec (
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .ctrl_i   (wdata_i[7:1]),
    .latch_o  (latch_cmd),
    .mode_wr_o(mode_wr),
    .err_o    (err_set[0])
  );
  assign err_set[NCH-1:1] = '0;

  for (genvar g = 0; g < NCH; g++) begin : g_cnt
    pit_counter #(.BYTE_W(BYTE_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .data_wr_i(wr_i && (addr_i == 2'(g))),
      .data_i   (wdata_i[BYTE_W-1:0]),
      .rd_i     (rd_i && (addr_i == 2'(g))),
      .latch_i  (latch_cmd[g]),
      .mode_wr_i(mode_wr[g]),
      .mode_i   (wdata_i[3:1]),
      .rd_byte_o(rd_byte[g]),
      .load_o   (ld_v[g]),
      .armed_o  (armed_v[g]),
      .tc_o     (tc_v[g]),
      .count_o  (cnt_v[g]),
      .latch_o  (latch_v[g]),
      .latched_o(latched_v[g]),
      .mode_o   (mode_v[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (|err_set)  err_q <= 1'b1;
  end
  assign err_o = err_q;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCH; i++)
      if (addr_i == 2'(i)) rdata_o = BUS_W'(rd_byte[i]);
    if (addr_i == ADDR_STAT) rdata_o[STAT_BIT] = tc_v[NCH-1];
  end

  // counter 0 has no status path
  logic unused_tc0;
  assign unused_tc0 = tc_v[0];
endmodule

// File: rtl/pit_two_chan_chk.sv
module pit_two_chan_chk #(
  parameter int NCH   = 2,
  parameter int CNT_W = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       tick_i,
  input logic                       wr_i,
  input logic [1:0]                 addr_i,
  input logic [7:0]                 rdata_o,
  input logic                       err_o,
  input logic [NCH-1:0]             ld_v,
  input logic [NCH-1:0]             armed_v,
  input logic [NCH-1:0]             tc_v,
  input logic [NCH-1:0]             latched_v,
  input logic [NCH-1:0][CNT_W-1:0]  cnt_v,
  input logic [NCH-1:0][CNT_W-1:0]  latch_v,
  input logic [NCH-1:0][2:0]        mode_v
);
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R11

  AST_STATUS_FMT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd3) |-> ((rdata_o & 8'hDF) == 8'h00)); // R6

  AST_TC_AT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tc_v[NCH-1]) |-> ($past(cnt_v[NCH-1]) == CNT_W'(1))); // R4

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_TICK_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_v[g] && tick_i && !ld_v[g]) |=> (cnt_v[g] == $past(cnt_v[g]) - 1'b1)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!armed_v[g] && !ld_v[g]) |=> $stable(cnt_v[g])); // R5

    AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      latched_v[g] |=> (!latched_v[g] || $stable(latch_v[g]))); // R9

    AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && addr_i == 2'd2) |=> $stable(mode_v[g])); // R10
  end
endmodule

bind pit_two_chan pit_two_chan_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i),
  .addr_i(addr_i), .rdata_o(rdata_o), .err_o(err_o), .ld_v(ld_v),
  .armed_v(armed_v), .tc_v(tc_v), .latched_v(latched_v), .cnt_v(cnt_v),
  .latch_v(latch_v), .mode_v(mode_v)
);

// File: tb/pit_two_chan_bench.sv
module pit_two_chan_bench;
  localparam int BW = 4;
  localparam int CW = 2 * BW;
  localparam int MAXV = 1 << CW;

  logic clk = 0, rst_ni = 0, tick_i = 0, wr_i = 0, rd_i = 0;
  logic [1:0] addr_i = 0;
  logic [7:0] wdata_i = 0, rdata_o;
  logic err_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  pit_two_chan #(.BYTE_W(BW)) u_pit_two_chan (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o));

  always #10 clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: act=hung exp=done");
    finish_run();
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; wr_i = 1;
    @(negedge clk); wr_i = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr_i = a; rd_i = 1; #1 v = rdata_o;
    @(negedge clk); rd_i = 0;
  endtask

  task automatic rd16(logic [1:0] a, output int v);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a, hi);
    v = {hi[3:0], lo[3:0]};
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick_i = 1;
    repeat (n) @(negedge clk);
    tick_i = 0;
  endtask

  // ch: 0 -> counter 0 (sel 00), 1 -> counter 2 (sel 10)
  task automatic load(int ch, int val, int mode);
    wr(2'd2, {(ch == 1) ? 2'b10 : 2'b00, 2'b11, 3'(mode), 1'b0});
    wr(2'(ch), 8'(val % 16));
    wr(2'(ch), 8'(val / 16));
  endtask

  logic [7:0] b;
  int v;

  initial begin
    do_reset();
    // R1 reset state
    rd(2'd3, b); chk("R1 status", b, 0);
    chk("R1 err", err_o, 0);
    rd16(2'd0, v); chk("R1 cnt0", v, 0);
    rd16(2'd1, v); chk("R1 cnt2", v, 0);
    // R5 unloaded counters hold
    ticks(10);
    rd16(2'd0, v); chk("R5 cnt0 idle", v, 0);
    rd16(2'd1, v); chk("R5 cnt2 idle", v, 0);
    rd(2'd3, b); chk("R5 status idle", b, 0);

    // R4/R3/R6 sweep of counter 2 over all nonzero loads
    for (int n = 1; n < MAXV; n++) begin
      load(1, n, n % 6);
      rd(2'd3, b); chk("R3 status cleared on load", b, 0);
      rd16(2'd1, v); chk("R7 live after load", v, n);
      ticks(n - 1);
      rd(2'd3, b); chk("R4 no tc before expiry", b, 0);
      ticks(1);
      rd(2'd3, b); chk("R4 tc at expiry (R6 0x20)", b, 8'h20);
    end

    // R4/R7 counter 0 sweep with wrap
    for (int n = 0; n < MAXV; n += 7) begin
      int k = (n * 5) % 23;
      load(0, n, 0);
      ticks(k);
      rd16(2'd0, v); chk("R4 cnt0 decrement/wrap", v, (n - k + MAXV) % MAXV);
    end

    // R3 interleaved loads
    wr(2'd2, 8'h30); wr(2'd2, 8'hB0);
    wr(2'd0, 8'h3); wr(2'd1, 8'h9); wr(2'd0, 8'hC); wr(2'd1, 8'h5);
    rd16(2'd0, v); chk("R3 interleave cnt0", v, 8'hC3);
    rd16(2'd1, v); chk("R3 interleave cnt2", v, 8'h59);

    // R8 latch capture and release
    load(0, 8'hA5, 2);
    wr(2'd2, 8'h00);
    ticks(3);
    rd16(2'd0, v); chk("R8 latched value", v, 8'hA5);
    rd16(2'd0, v); chk("R8 live after release", v, 8'hA2);
    // R9 second latch ignored
    load(0, 8'h80, 2);
    wr(2'd2, 8'h00);
    ticks(2);
    wr(2'd2, 8'h00);
    ticks(1);
    rd16(2'd0, v); chk("R9 first latch kept", v, 8'h80);
    rd16(2'd0, v); chk("R9 live after", v, 8'h7D);
    // R8 latch on counter 2
    load(1, 8'h40, 0);
    wr(2'd2, 8'h80);
    ticks(4);
    rd16(2'd1, v); chk("R8 latched cnt2", v, 8'h40);
    rd16(2'd1, v); chk("R8 live cnt2", v, 8'h3C);

    // R10 mode has no effect
    for (int m = 0; m < 8; m++) begin
      load(1, 20, m);
      ticks(5);
      rd16(2'd1, v); chk("R10 mode no effect", v, 15);
    end

    // R11 unsupported commands
    chk("R11 err clear before", err_o, 0);
    load(0, 8'h33, 0);
    wr(2'd2, 8'hC0);
    @(negedge clk); chk("R11 readback sets err", err_o, 1);
    wr(2'd2, 8'h40); wr(2'd2, 8'h10); wr(2'd2, 8'h20);
    ticks(1);
    rd16(2'd0, v); chk("R11 counter untouched", v, 8'h32);
    wr(2'd2, 8'h36);
    @(negedge clk); chk("R11 err sticky", err_o, 1);
    do_reset();
    chk("R11 err cleared by reset", err_o, 0);
    wr(2'd2, 8'h10);
    @(negedge clk); chk("R11 access 01 err", err_o, 1);
    do_reset();
    wr(2'd2, 8'hA0);
    @(negedge clk); chk("R11 access 10 err", err_o, 1);
    do_reset();
    wr(2'd2, 8'h70);
    @(negedge clk); chk("R11 counter 1 err", err_o, 1);
    do_reset();
    wr(2'd2, 8'hB4);
    @(negedge clk); chk("R2 valid word no err", err_o, 0);

    finish_run();
  end
endmodule